// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block sits beside a single-data-rate SDRAM command bus and follows it one clock at a time. Each clock it turns the sampled chip-select, row strobe, column strobe and write-enable levels, together with clock enable, the two bank-select bits and address bit 10, into one command code. It keeps a state for each of the four banks and checks whether the command is allowed against those states. Commands that break a rule raise a one-cycle illegal pulse with a reason code. They do not change any bank state, so the monitor stays in step with what a correct memory would do.

Each bank state that only lasts a while counts down by itself. Such states are row opening, precharge, burst, write recovery, refresh and mode-register access. All timing limits are parameters counted in clocks. The block is meant for simulation harnesses and for on-chip protocol checking next to a memory controller. It does not look at data or at electrical timing.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Each clock the block decodes the command. Chip select high gives deselect (code 0). With chip select low, the row/column/write-enable levels map as follows: LLL mode set (2), LLH refresh (3 if clock enable is high, 4 self refresh if it is low), LHL precharge (5), LHH activate (6), HLL write (7), HLH read (8), HHL burst stop (9), HHH no-op (1). `cmd_o` shows the code after the edge on which the command was sampled.
- R2: Reset puts every bank in idle and clears the pulse and the reason. Bank b reports its state in `bank_state_o[4b+3:4b]`. The codes are: idle 0, opening 1, row open 2, read burst 3, write burst 4, read burst with auto-precharge 5, write burst with auto-precharge 6, write recovery 7, write recovery before auto-precharge 8, precharging 9, refreshing 10, mode access 11.
- R3: `illegal_o` is high for exactly the cycle after an illegal command. `reason_o` is zero or one-hot: bit 0 means the bank state forbids the command, bit 1 means a device-wide command was issued while not all banks were idle, bit 2 means an activate came too soon. When more than one applies, the lowest bit wins.
- R4: These are bank-state violations: a read or write to a bank that is not open, in a plain burst or in write recovery; an activate to a bank that is not idle; a precharge to a bank that is opening, in an auto-precharge burst, in any write recovery, precharging, refreshing or in mode access; a burst stop when no bank is in a plain read or write burst.
- R5: An activate at edge t puts the bank in opening. A read or write to that bank is legal from edge t+T_RCD.
- R6: A precharge with address bit 10 high acts on all banks; with it low it acts only on the selected bank. Banks that are already idle stay idle, and the command is legal. A precharge at edge t makes the bank idle for commands from edge t+T_RP.
- R7: Refresh, self refresh and mode set need all banks idle. After a refresh at edge t, every bank is refreshing until commands from edge t+T_RC see idle. After a mode set, idle is seen from edge t+2.
- R8: A read with bit 10 high at edge t is an auto-precharge burst for BURST_LEN clocks. Precharge then runs T_RP clocks, and the bank is idle from edge t+BURST_LEN+T_RP.
- R9: A write at edge t bursts for BURST_LEN clocks and then recovers for T_WR clocks. A plain write returns to row open from edge t+BURST_LEN+T_WR. With bit 10 high, precharging follows for T_RP clocks, and the bank is idle from edge t+BURST_LEN+T_WR+T_RP.
- R10: A read, write or precharge to a bank in a plain burst replaces that burst at once. A burst stop ends a plain read burst into row open and a plain write burst into write recovery.
- R11: An activate less than T_RRD clocks after the last legal activate is a spacing violation.
- R12: An illegal command leaves every bank state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, commands sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable level in the current cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| a10 | input | 1 | Auto-precharge / all-bank flag |
| cmd_o | output | 4 | Decoded command code (R1) |
| bank_state_o | output | 4*2^BA_W | Packed per-bank state codes (R2) |
| illegal_o | output | 1 | One-cycle illegal-command pulse |
| reason_o | output | 3 | One-hot violation reason (R3) |

## Verification
The bench moves the gap after activate, precharge, refresh, mode set and activate-to-activate through every value around each limit. A counter that is off by one shows up as a wrong verdict on one side of the limit. It follows both auto-precharge sequences and the plain write cycle by cycle. A chain that skips write recovery, or that goes back to row open instead of idle, gives a wrong state code partway through. It also covers burst termination, burst stop into recovery, precharge-all on a mix of idle and open banks, and illegal commands that must leave state alone. A design that let a rejected command change a bank would be seen there.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int BA_W      = 2,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RC      = 6,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke,
  input  logic                    cs_n,
  input  logic                    ras_n,
  input  logic                    cas_n,
  input  logic                    we_n,
  input  logic [BA_W-1:0]         ba,
  input  logic                    a10,
  output logic [3:0]              cmd_o,
  output logic [4*(1<<BA_W)-1:0]  bank_state_o,
  output logic                    illegal_o,
  output logic [2:0]              reason_o
);
  localparam int NB = 1 << BA_W;
  localparam int CW = $clog2(T_RCD + T_RP + T_RC + T_RRD + T_WR + BURST_LEN) + 1;

  localparam logic [3:0] C_DES = 4'd0, C_NOP = 4'd1, C_MRS = 4'd2, C_REF = 4'd3,
                         C_SRF = 4'd4, C_PRE = 4'd5, C_ACT = 4'd6, C_WR  = 4'd7,
                         C_RD  = 4'd8, C_BST = 4'd9;
  localparam logic [3:0] S_IDLE = 4'd0, S_OPEN = 4'd1, S_ROW = 4'd2, S_RD = 4'd3,
                         S_WR = 4'd4, S_RDA = 4'd5, S_WRA = 4'd6, S_WREC = 4'd7,
                         S_WRECA = 4'd8, S_PRE = 4'd9, S_REF = 4'd10, S_MODE = 4'd11;

  logic [3:0]    cmd;
  logic [3:0]    st    [NB];
  logic [3:0]    st_n  [NB];
  logic [CW-1:0] cnt   [NB];
  logic [CW-1:0] cnt_n [NB];
  logic [CW-1:0] rrd;
  logic [NB-1:0] tgt, bad;
  logic          all_idle, any_burst, bank_bad, idle_bad, spc_bad, ok;
  logic [2:0]    reason;

  always_comb begin
    if (cs_n) cmd = C_DES;
    else case ({ras_n, cas_n, we_n})
      3'b000:  cmd = C_MRS;
      3'b001:  cmd = cke ? C_REF : C_SRF;
      3'b010:  cmd = C_PRE;
      3'b011:  cmd = C_ACT;
      3'b100:  cmd = C_WR;
      3'b101:  cmd = C_RD;
      3'b110:  cmd = C_BST;
      default: cmd = C_NOP;
    endcase
  end

  always_comb begin
    all_idle  = 1'b1;
    any_burst = 1'b0;
    for (int b = 0; b < NB; b++) begin
      all_idle  = all_idle & (st[b] == S_IDLE);
      any_burst = any_burst | (st[b] == S_RD) | (st[b] == S_WR);
      tgt[b] = (cmd == C_PRE && a10) ||
               ((cmd == C_PRE || cmd == C_ACT || cmd == C_RD || cmd == C_WR) && ba == BA_W'(b));
      case (cmd)
        C_ACT:       bad[b] = st[b] != S_IDLE;
        C_RD, C_WR:  bad[b] = !(st[b] inside {S_ROW, S_RD, S_WR, S_WREC});
        C_PRE:       bad[b] = !(st[b] inside {S_IDLE, S_ROW, S_RD, S_WR});
        default:     bad[b] = 1'b0;
      endcase
    end
  end

  assign bank_bad = (cmd == C_BST) ? !any_burst : |(tgt & bad);
  assign idle_bad = (cmd == C_MRS || cmd == C_REF || cmd == C_SRF) && !all_idle;
  assign spc_bad  = (cmd == C_ACT) && (rrd != '0);
  assign reason   = bank_bad ? 3'b001 : idle_bad ? 3'b010 : spc_bad ? 3'b100 : 3'b000;
  assign ok       = reason == 3'b000;

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      st_n[b]  = st[b];
      cnt_n[b] = cnt[b];
      if (ok && tgt[b]) begin
        case (cmd)
          C_ACT: begin st_n[b] = S_OPEN; cnt_n[b] = CW'(T_RCD - 2); end
          C_RD:  begin st_n[b] = a10 ? S_RDA : S_RD; cnt_n[b] = CW'(BURST_LEN - 2); end
          C_WR:  begin st_n[b] = a10 ? S_WRA : S_WR; cnt_n[b] = CW'(BURST_LEN - 2); end
          default: if (st[b] != S_IDLE) begin st_n[b] = S_PRE; cnt_n[b] = CW'(T_RP - 2); end
        endcase
      end else if (ok && cmd == C_MRS) begin
        st_n[b] = S_MODE; cnt_n[b] = '0;
      end else if (ok && (cmd == C_REF || cmd == C_SRF)) begin
        st_n[b] = S_REF; cnt_n[b] = CW'(T_RC - 2);
      end else if (ok && cmd == C_BST && st[b] == S_RD) begin
        st_n[b] = S_ROW;
      end else if (ok && cmd == C_BST && st[b] == S_WR) begin
        st_n[b] = S_WREC; cnt_n[b] = CW'(T_WR - 1);
      end else if (st[b] != S_IDLE && st[b] != S_ROW) begin
        if (cnt[b] != '0) cnt_n[b] = cnt[b] - CW'(1);
        else case (st[b])
          S_OPEN, S_RD, S_WREC: st_n[b] = S_ROW;
          S_WR:          begin st_n[b] = S_WREC;  cnt_n[b] = CW'(T_WR - 1); end
          S_WRA:         begin st_n[b] = S_WRECA; cnt_n[b] = CW'(T_WR - 1); end
          S_RDA, S_WRECA: begin st_n[b] = S_PRE;  cnt_n[b] = CW'(T_RP - 1); end
          default:       st_n[b] = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        st[b]  <= S_IDLE;
        cnt[b] <= '0;
      end
      rrd       <= '0;
      cmd_o     <= C_DES;
      illegal_o <= 1'b0;
      reason_o  <= 3'b000;
    end else begin
      for (int b = 0; b < NB; b++) begin
        st[b]  <= st_n[b];
        cnt[b] <= cnt_n[b];
      end
      if (ok && cmd == C_ACT) rrd <= CW'(T_RRD - 1);
      else if (rrd != '0)     rrd <= rrd - CW'(1);
      cmd_o     <= cmd;
      illegal_o <= !ok;
      reason_o  <= reason;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_pack
    assign bank_state_o[4*g +: 4] = st[g];
  end
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int BA_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cke,
  input logic                   cs_n,
  input logic                   ras_n,
  input logic                   cas_n,
  input logic                   we_n,
  input logic [BA_W-1:0]        ba,
  input logic                   a10,
  input logic [3:0]             cmd_o,
  input logic [4*(1<<BA_W)-1:0] bank_state_o,
  input logic                   illegal_o,
  input logic [2:0]             reason_o
);
  logic [3:0] sel_st;
  assign sel_st = bank_state_o[4*int'(ba) +: 4];

  // R3
  reason_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reason_o) && (illegal_o == (reason_o != 3'b000)));

  // R1
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> cmd_o == 4'd0);

  // R4
  read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && ras_n && !cas_n && we_n && sel_st == 4'd0) |=> (illegal_o && reason_o[0]));

  // R7
  mode_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && !cas_n && !we_n && cke && a10 == a10 && bank_state_o != '0) |=> reason_o[1]);

  // R5
  act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && cas_n && we_n && sel_st == 4'd0) |=>
      (illegal_o || bank_state_o[4*int'($past(ba)) +: 4] == 4'd1));

  // R6
  pre_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_state_o[3:0] == 4'd9) |=> (bank_state_o[3:0] == 4'd9 || bank_state_o[3:0] == 4'd0));
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.BA_W(BA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .a10(a10), .cmd_o(cmd_o), .bank_state_o(bank_state_o),
  .illegal_o(illegal_o), .reason_o(reason_o)
);

// File: tb/sdram_cmd_monitor_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_tb_top;
  localparam int RCD = 3, RP = 3, RC = 6, RRD = 2, WRT = 2, BL = 4;
  localparam int DES = 0, NOP = 1, MRS = 2, REF = 3, SRF = 4, PRE = 5, ACT = 6, WR = 7, RD = 8, BST = 9;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0]  ba = 2'd0;
  logic [3:0]  cmd_o;
  logic [15:0] bank_state_o;
  logic        illegal_o;
  logic [2:0]  reason_o;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_monitor #(.BA_W(2), .T_RCD(RCD), .T_RP(RP), .T_RC(RC), .T_RRD(RRD),
                      .T_WR(WRT), .BURST_LEN(BL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .cmd_o(cmd_o), .bank_state_o(bank_state_o),
    .illegal_o(illegal_o), .reason_o(reason_o));

  task automatic check(string r, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int st(int b);
    return int'(bank_state_o[4*b +: 4]);
  endfunction

  task automatic send(int c, int b = 0, bit a = 1'b0);
    cke = (c != SRF);
    ba = 2'(b);
    a10 = a;
    cs_n = (c == DES);
    case (c)
      MRS:      {ras_n, cas_n, we_n} = 3'b000;
      REF, SRF: {ras_n, cas_n, we_n} = 3'b001;
      PRE:      {ras_n, cas_n, we_n} = 3'b010;
      ACT:      {ras_n, cas_n, we_n} = 3'b011;
      WR:       {ras_n, cas_n, we_n} = 3'b100;
      RD:       {ras_n, cas_n, we_n} = 3'b101;
      BST:      {ras_n, cas_n, we_n} = 3'b110;
      default:  {ras_n, cas_n, we_n} = 3'b111;
    endcase
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) send(DES);
  endtask

  task automatic rst();
    rst_n = 1'b0;
    cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int e_rda(int j);
    if (j <= BL - 2) return 5;
    if (j <= BL + RP - 2) return 9;
    return 0;
  endfunction
  function automatic int e_wra(int j);
    if (j <= BL - 2) return 6;
    if (j <= BL + WRT - 2) return 8;
    if (j <= BL + WRT + RP - 2) return 9;
    return 0;
  endfunction
  function automatic int e_wr(int j);
    if (j <= BL - 2) return 4;
    if (j <= BL + WRT - 2) return 7;
    return 2;
  endfunction

  initial begin
    #200000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst();
    check("R2 reset states", int'(bank_state_o), 0);
    check("R2 reset pulse", int'(illegal_o), 0);
    check("R2 reset reason", int'(reason_o), 0);

    // R1 decode sweep of the stateless codes
    send(NOP);  check("R1 nop", int'(cmd_o), NOP);
    send(DES);  check("R1 deselect", int'(cmd_o), DES);
    send(BST);  check("R1 burst stop", int'(cmd_o), BST);
    check("R4 burst stop idle", int'(reason_o), 1);
    send(DES);  check("R3 pulse single cycle", int'(illegal_o), 0);

    // R4 bank-state violations
    rst(); send(RD, 0);  check("R1 read", int'(cmd_o), RD);
    check("R4 read idle", int'(reason_o), 1);
    send(WR, 1);  check("R1 write", int'(cmd_o), WR);
    check("R4 write idle", int'(reason_o), 1);
    send(ACT, 0); check("R1 activate", int'(cmd_o), ACT);
    idle(RCD); send(ACT, 0);
    check("R4 activate open row", int'(reason_o), 1);
    check("R12 open row kept", st(0), 2);

    // R5 activate-to-column sweep
    for (int k = 1; k <= RCD + 1; k++) begin
      rst(); send(ACT, 0);
      check("R5 opening state", st(0), 1);
      idle(k - 1); send(RD, 0);
      check("R5 read after activate", int'(illegal_o), (k < RCD) ? 1 : 0);
    end

    // R6 precharge-to-activate sweep
    for (int k = 1; k <= RP + 1; k++) begin
      rst(); send(ACT, 1); idle(RCD - 1); send(PRE, 1, 1'b0);
      check("R1 precharge", int'(cmd_o), PRE);
      check("R6 precharging", st(1), 9);
      idle(k - 1); send(ACT, 1);
      check("R6 activate after precharge", int'(illegal_o), (k < RP) ? 1 : 0);
    end
    rst(); send(PRE, 2, 1'b0);
    check("R6 precharge idle bank legal", int'(illegal_o), 0);
    check("R6 idle bank stays idle", st(2), 0);
    rst(); send(ACT, 0); idle(RRD - 1); send(ACT, 3); idle(RCD); send(PRE, 2, 1'b1);
    check("R6 precharge all legal", int'(illegal_o), 0);
    check("R6 all-bank states", int'(bank_state_o), 16'h9009);

    // R7 refresh and mode-set sweeps
    for (int k = 1; k <= RC + 1; k++) begin
      rst(); send(REF);
      check("R1 refresh", int'(cmd_o), REF);
      check("R7 refreshing all", int'(bank_state_o), 16'hAAAA);
      idle(k - 1); send(ACT, 2);
      check("R7 activate after refresh", int'(illegal_o), (k < RC) ? 1 : 0);
    end
    for (int k = 1; k <= 3; k++) begin
      rst(); send(MRS);
      check("R1 mode set", int'(cmd_o), MRS);
      check("R7 mode access all", int'(bank_state_o), 16'hBBBB);
      idle(k - 1); send(ACT, 0);
      check("R7 activate after mode set", int'(illegal_o), (k < 2) ? 1 : 0);
    end
    rst(); send(ACT, 0); idle(RCD); send(REF);
    check("R7 refresh with open bank", int'(reason_o), 2);
    check("R12 refresh rejected keeps state", int'(bank_state_o), 16'h0002);
    rst(); send(SRF);
    check("R1 self refresh", int'(cmd_o), SRF);
    check("R7 self refresh states", int'(bank_state_o), 16'hAAAA);

    // R8 auto-precharge read sequence
    rst(); send(ACT, 2); idle(RCD - 1); send(RD, 2, 1'b1);
    for (int j = 0; j <= BL + RP; j++) begin
      check("R8 read auto-precharge state", st(2), e_rda(j));
      send(DES);
    end
    rst(); send(ACT, 2); idle(RCD - 1); send(RD, 2, 1'b1); send(RD, 2);
    check("R8 read during auto-precharge", int'(reason_o), 1);
    check("R12 auto-precharge burst kept", st(2), 5);

    // R9 write sequences
    rst(); send(ACT, 1); idle(RCD - 1); send(WR, 1, 1'b1);
    for (int j = 0; j <= BL + WRT + RP; j++) begin
      check("R9 write auto-precharge state", st(1), e_wra(j));
      send(DES);
    end
    rst(); send(ACT, 3); idle(RCD - 1); send(WR, 3);
    for (int j = 0; j <= BL + WRT; j++) begin
      check("R9 plain write state", st(3), e_wr(j));
      send(DES);
    end
    rst(); send(ACT, 0); idle(RCD - 1); send(WR, 0); idle(BL - 1); send(PRE, 0);
    check("R4 precharge in write recovery", int'(reason_o), 1);

    // R10 burst termination
    rst(); send(ACT, 0); idle(RCD - 1); send(RD, 0); send(WR, 0);
    check("R10 write ends read burst", int'(illegal_o), 0);
    check("R10 write burst state", st(0), 4);
    send(BST);
    check("R10 stop write burst", st(0), 7);
    rst(); send(ACT, 0); idle(RCD - 1); send(RD, 0); send(BST);
    check("R10 stop read burst", st(0), 2);
    rst(); send(ACT, 0); idle(RCD - 1); send(RD, 0); send(PRE, 0);
    check("R10 precharge ends burst", st(0), 9);

    // R11 activate spacing sweep
    for (int k = 1; k <= RRD + 1; k++) begin
      rst(); send(ACT, 0); idle(k - 1); send(ACT, 1);
      check("R11 activate spacing", int'(reason_o), (k < RRD) ? 4 : 0);
      check("R12 spaced bank state", st(1), (k < RRD) ? 0 : 1);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule